// File: doc/BRIEF.md
# UART Automatic Baud Rate Detector

This block works out the bit time of a serial character arriving on an asynchronous receive line and turns it into the divisor for a baud generator that samples sixteen times per bit. Software picks a measurement mode and sets a start bit in the control register. While the start bit is set, the block tells the receiver to sample at its fastest rate and gives a one-cycle flush pulse to the receive shift logic. The block then waits for the falling edge that begins a start bit.

From that edge on, it counts clock cycles through a divide-by-sixteen prescaler. The count stops on a closing edge that depends on the mode. One mode closes on the rising edge that ends the start bit. The other mode closes on the next falling edge, so it spans the start bit and a data LSB of 1, as in an ASCII 'A' or 'a'. That second mode halves the count before using it.

When the count stops, it is written into the divisor register and the start bit clears itself. The end-of-detection flag is raised if its enable bit is set. If the count would pass its maximum before the closing edge, the run is abandoned and the divisor is left as it was. In that case the timeout flag is raised if enabled. A start request is refused while the fractional divider add value is nonzero.

Top module: `uart_autobaud`

## Requirements
- R1: After reset the divisor is 0, both interrupt flags and outputs are 0, the control register reads 0, and `rx_fast_o` is 0.
- R2: Writing 1 to control bit 0 (start) while `frac_add_i` is 0 drives `rx_fast_o` high and pulses `rx_flush_o` for exactly one cycle. Nothing is measured until a falling edge is seen on the receive line.
- R3: A start write while `frac_add_i` is nonzero leaves start at 0 and `rx_fast_o` low. The other control bits are still written.
- R4: With control bit 1 (mode) = 1, the divisor becomes floor(N/16). N is the number of clock cycles between the falling edge and the next rising edge on `rxd_i`.
- R5: With mode = 0, the divisor becomes floor(N/16) shifted right by one. N is the number of cycles between the first falling edge and the next falling edge, and any rising edge between them is ignored.
- R6: Completion sets the done flag (status bit 0, `irq_done_o`) only when control bit 2 is 1. Writing 1 to status bit 0 clears the flag.
- R7: On completion or timeout, start clears itself and `rx_fast_o` returns low.
- R8: If the count would exceed 2^CNT_W-1 before the closing edge, the run aborts with the divisor unchanged. The timeout flag (status bit 1, `irq_tmo_o`) is set only when control bit 3 is 1, and writing 1 to status bit 1 clears it.
- R9: Register map: address 0 is control, address 1 is status/clear, address 2 is divisor bits [7:0] and address 3 is divisor bits [15:8]. The divisor bytes are writable only while start is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Asynchronous receive line, idle high |
| frac_add_i | input | 4 | Fractional divider add value; start is refused when nonzero |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` (combinational) |
| div_o | output | 16 | Divisor for the sixteen-times oversampling baud generator |
| rx_fast_o | output | 1 | Receiver forced to its fastest sampling rate |
| rx_flush_o | output | 1 | One-cycle reset of the receive shift state |
| irq_done_o | output | 1 | End-of-detection interrupt flag |
| irq_tmo_o | output | 1 | Timeout interrupt flag |

## Verification
Some properties are checked by assertions on every cycle:
- the count never steps backwards during a measurement;
- completion fires only on the edge its mode selects;
- a timeout leaves the divisor untouched;
- start drops after any ending;
- each flag rises only with its enable set.

Other behaviour only the bench scenarios can show: the divisor values for given bit lengths in both modes, the rounding of spans that are not whole multiples, the refusal under a nonzero fractional add value, and the write-one-to-clear behaviour.

// File: rtl/ab_pkg.sv
package ab_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_MEAS = 2'd2
  } ab_state_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DLO  = 2'd2;
  localparam logic [1:0] ADDR_DHI  = 2'd3;
endpackage

// File: rtl/ab_sync.sv
module ab_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd_i,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= rxd_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];

  assign fall_o = prev_q & ~chain_q[STAGES-1];
  assign rise_o = ~prev_q & chain_q[STAGES-1];
endmodule

// File: rtl/ab_meter.sv
module ab_meter
  import ab_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRESC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             arm_i,
  input  logic             mode_i,
  input  logic             fall_i,
  input  logic             rise_i,
  output logic             done_o,
  output logic             tmo_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int PW = $clog2(PRESC);
  localparam logic [PW-1:0]    PRE_LAST = PW'(PRESC - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  ab_state_t        state_q;
  logic [PW-1:0]    pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             stop_edge, tick, live;

  assign live      = start_i && !arm_i && state_q == ST_MEAS;
  assign stop_edge = mode_i ? rise_i : fall_i;
  assign tick      = pre_q == PRE_LAST;
  assign done_o    = live && stop_edge;
  assign tmo_o     = live && !stop_edge && tick && cnt_q == CNT_MAX;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pre_q   <= '0;
      cnt_q   <= '0;
    end else if (!start_i) begin
      state_q <= ST_IDLE;
    end else if (arm_i) begin
      state_q <= ST_ARM;
      pre_q   <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_ARM: if (fall_i) begin
          state_q <= ST_MEAS;
          pre_q   <= PW'(1);
          cnt_q   <= '0;
        end
        ST_MEAS: begin
          if (done_o || tmo_o) begin
            state_q <= ST_IDLE;
          end else if (tick) begin
            pre_q <= '0;
            cnt_q <= cnt_q + 1'b1;
          end else begin
            pre_q <= pre_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MEAS && $past(state_q) == ST_MEAS) |-> cnt_q >= $past(cnt_q)); // R8
  AST_DONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (mode_i ? !fall_i : !rise_i)); // R5
endmodule

// File: rtl/ab_regs.sv
module ab_regs
  import ab_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic [3:0]       frac_add_i,
  input  logic             done_i,
  input  logic             tmo_i,
  input  logic [DIV_W-1:0] load_i,
  output logic             start_o,
  output logic             arm_o,
  output logic             mode_o,
  output logic [DIV_W-1:0] div_o,
  output logic             irq_done_o,
  output logic             irq_tmo_o
);
  logic             start_q, arm_q, mode_q, done_ie_q, tmo_ie_q;
  logic             done_f_q, tmo_f_q;
  logic [DIV_W-1:0] div_q;
  logic             wr_ctrl, wr_stat, start_ok;

  assign wr_ctrl  = wr_i && addr_i == ADDR_CTRL;
  assign wr_stat  = wr_i && addr_i == ADDR_STAT;
  assign start_ok = wdata_i[0] && frac_add_i == 4'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0; arm_q <= 1'b0; mode_q <= 1'b0;
      done_ie_q <= 1'b0; tmo_ie_q <= 1'b0;
      done_f_q <= 1'b0; tmo_f_q <= 1'b0;
      div_q <= '0;
    end else begin
      arm_q <= wr_ctrl && start_ok;
      if (wr_ctrl) begin
        start_q   <= start_ok;
        mode_q    <= wdata_i[1];
        done_ie_q <= wdata_i[2];
        tmo_ie_q  <= wdata_i[3];
      end else if (done_i || tmo_i) begin
        start_q <= 1'b0;
      end
      if (done_i) div_q <= load_i;
      else if (wr_i && !start_q && addr_i == ADDR_DLO) div_q[7:0] <= wdata_i;
      else if (wr_i && !start_q && addr_i == ADDR_DHI) div_q[DIV_W-1:8] <= wdata_i[DIV_W-9:0];
      if (done_i && done_ie_q)        done_f_q <= 1'b1;
      else if (wr_stat && wdata_i[0]) done_f_q <= 1'b0;
      if (tmo_i && tmo_ie_q)          tmo_f_q <= 1'b1;
      else if (wr_stat && wdata_i[1]) tmo_f_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = {4'd0, tmo_ie_q, done_ie_q, mode_q, start_q};
      ADDR_STAT: rdata_o = {6'd0, tmo_f_q, done_f_q};
      ADDR_DLO:  rdata_o = div_q[7:0];
      default:   rdata_o = div_q[DIV_W-1:8];
    endcase
  end

  assign start_o    = start_q;
  assign arm_o      = arm_q;
  assign mode_o     = mode_q;
  assign div_o      = div_q;
  assign irq_done_o = done_f_q;
  assign irq_tmo_o  = tmo_f_q;

  AST_TMO_KEEPS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_i |=> $stable(div_q)); // R8
  AST_START_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_i || tmo_i) && !wr_i) |=> !start_q); // R7
  AST_DONE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_f_q) |-> $past(done_ie_q)); // R6
  AST_TMO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_f_q) |-> $past(tmo_ie_q)); // R8
  AST_ARM_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |-> start_q); // R2
endmodule

// File: rtl/uart_autobaud.sv
module uart_autobaud #(
  parameter int CNT_W       = 16,
  parameter int PRESC       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxd_i,
  input  logic [3:0]  frac_add_i,
  input  logic        reg_wr_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic [15:0] div_o,
  output logic        rx_fast_o,
  output logic        rx_flush_o,
  output logic        irq_done_o,
  output logic        irq_tmo_o
);
  localparam int DIV_W = 16;

  logic             fall, rise, start, arm, mode, done_evt, tmo_evt;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] load_val;

  ab_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd_i), .fall_o(fall), .rise_o(rise));

  ab_meter #(.CNT_W(CNT_W), .PRESC(PRESC)) i_meter (
    .clk(clk), .rst_n(rst_n), .start_i(start), .arm_i(arm), .mode_i(mode),
    .fall_i(fall), .rise_i(rise), .done_o(done_evt), .tmo_o(tmo_evt), .cnt_o(cnt));

  assign load_val = mode ? DIV_W'(cnt) : DIV_W'(cnt >> 1);

  ab_regs #(.DIV_W(DIV_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .frac_add_i(frac_add_i),
    .done_i(done_evt), .tmo_i(tmo_evt), .load_i(load_val), .start_o(start),
    .arm_o(arm), .mode_o(mode), .div_o(div_o), .irq_done_o(irq_done_o),
    .irq_tmo_o(irq_tmo_o));

  assign rx_fast_o  = start;
  assign rx_flush_o = arm;

  AST_ONE_ENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_evt, tmo_evt, arm})); // R7
  AST_NO_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt || tmo_evt) |-> start); // R2
endmodule

// File: tb/test_uart_autobaud.sv
module test_uart_autobaud;
  localparam int CNT_W = 10;

  logic clk = 0, rst_n = 0, rxd = 1, wr = 0;
  logic [3:0] frac = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [15:0] div;
  logic fast, flush, irq_d, irq_t;
  int checks = 0, errors = 0, flushes = 0;

  always #2.5 clk = ~clk;

  uart_autobaud #(.CNT_W(CNT_W)) i_uart_autobaud (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .frac_add_i(frac), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .div_o(div),
    .rx_fast_o(fast), .rx_flush_o(flush), .irq_done_o(irq_d), .irq_tmo_o(irq_t));

  always @(negedge clk) if (flush) flushes++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {mode, bit length in cycles}; mode 1: div = L/16, mode 0: div = (2L/16)>>1
  typedef struct packed { logic mode; logic [15:0] len; } vec_t;
  localparam vec_t VECS [7] = '{
    '{1'b1, 16'd160}, '{1'b1, 16'd167}, '{1'b0, 16'd160}, '{1'b0, 16'd169},
    '{1'b1, 16'd16},  '{1'b0, 16'd48},  '{1'b1, 16'd4000}};

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int exp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    // R1 reset state
    chk("R1 div", div, 0);
    chk("R1 irq", {irq_d, irq_t}, 0);
    chk("R1 fast", fast, 0);
    rreg(2'd0, r); chk("R1 ctrl", r, 0);

    foreach (VECS[i]) begin
      wreg(2'd0, {4'b0001, 2'b01, VECS[i].mode, 1'b1});
      idle(5);
      rxd = 0; idle(VECS[i].len);
      rxd = 1;
      if (!VECS[i].mode) begin idle(VECS[i].len); rxd = 0; end
      idle(8);
      rxd = 1;
      idle(4);
      if (VECS[i].mode) exp = VECS[i].len / 16;
      else exp = ((2 * VECS[i].len) / 16) >> 1;
      chk(VECS[i].mode ? "R4 div" : "R5 div", div, exp);
      chk("R6 irq_done", irq_d, 1);
      chk("R7 start clear", fast, 0);
      wreg(2'd1, 8'h01);
      chk("R6 clear", irq_d, 0);
    end

    // R2: start gives fast + one flush, no measurement on idle line
    flushes = 0;
    wreg(2'd0, 8'h07);
    idle(100);
    chk("R2 fast", fast, 1);
    chk("R2 flush", flushes, 1);
    chk("R2 no done", irq_d, 0);
    // R9 divisor not writable while started
    wreg(2'd2, 8'h55);
    chk("R9 div locked", div, 250);
    wreg(2'd0, 8'h00);
    chk("R7 stop", fast, 0);
    // R9 divisor bytes writable when idle
    wreg(2'd2, 8'h34); wreg(2'd3, 8'h12);
    chk("R9 div write", div, 16'h1234);
    rreg(2'd3, r); chk("R9 hi read", r, 8'h12);

    // R6 done flag gated by enable
    wreg(2'd0, 8'h03);
    idle(3); rxd = 0; idle(64); rxd = 1; idle(8);
    chk("R6 no flag", irq_d, 0);
    chk("R6 div", div, 4);

    // R3 refused with fractional add nonzero
    frac = 4'd3;
    wreg(2'd0, 8'h0F);
    chk("R3 fast", fast, 0);
    rreg(2'd0, r); chk("R3 ctrl", r, 8'h0E);
    frac = 0;

    // R8 timeout: 2^CNT_W*16 cycles of low line
    wreg(2'd2, 8'h21); wreg(2'd3, 8'h00);
    wreg(2'd0, 8'h0B);
    idle(3); rxd = 0; idle(17000); rxd = 1; idle(8);
    chk("R8 tmo flag", irq_t, 1);
    chk("R8 div kept", div, 16'h0021);
    chk("R8 start clear", fast, 0);
    rreg(2'd1, r); chk("R8 stat", r, 8'h02);
    wreg(2'd1, 8'h02);
    chk("R8 clear", irq_t, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule